// File: doc/BRIEF.md
# Nonvolatile Store/Recall Cycle Controller

This block sequences the two bulk transfers of a battery-free nonvolatile SRAM: STORE, which copies the SRAM into the nonvolatile array, and RECALL, which loads that copy back into the SRAM. A shared open-drain busy/request line, a pair of supply comparators and software triggers can all start a cycle. The block pulls the busy line low while a STORE runs. It gates the host's read and write strobes, and it sends one-cycle start pulses to an array-copy engine outside the block. Every duration is counted in clock cycles.

A dirty flag records whether the SRAM has been written since the last nonvolatile cycle. STOREs requested over the busy line or by supply loss are skipped when the flag is clear. A software STORE always runs. After any STORE, or after a skipped one, access stays closed until the shared line is seen high again, and then for a recovery interval.

Top module: `nv_cycle_ctrl`

## Requirements
- R1: While reset is held, `busy_drv`, `rd_pass`, `wr_pass`, `store_go` and `recall_go` are 0. A RECALL is pending out of reset. It starts once both supply comparators read high, pulses `recall_go` in its first cycle, and keeps reads closed for exactly RESTORE_CYC cycles.
- R2: A write that passes the gate sets the dirty flag. Completion of any STORE or RECALL clears it.
- R3: With the dirty flag set, a low level on `busy_in` (supply above the switch level) opens a DELAY_CYC window. A STORE follows, with `store_go` in its first cycle and `busy_drv` high for exactly STORE_CYC cycles.
- R4: With the dirty flag clear, the same request produces no `store_go` and no `busy_drv`.
- R5: After a STORE ends, or after a skipped one, reads and writes stay closed while `busy_in` is low. After `busy_in` is seen high they stay closed for exactly RECOVER_CYC cycles more.
- R6: During the delay window reads pass and writes are blocked.
- R7: When `sup_above_sw` falls while the block is idle, `busy_drv` goes high for ALERT_CYC cycles. If the dirty flag is clear, the line is then released and no STORE follows.
- R8: If the dirty flag is set at the end of that alert, the STORE follows at once. `busy_drv` then stays high for ALERT_CYC+STORE_CYC cycles in total.
- R9: If `busy_in` is still high at the end of the alert, the automatic attempt is abandoned. No STORE follows, and access reopens on the next cycle.
- R10: While `sup_above_sw` is low, `wr_pass` is 0, and a low `busy_in` starts no STORE.
- R11: A drop of `sup_above_rst` closes all access and latches a RECALL, which runs when both comparators are high again. A supply dip that stays above the reset level causes no RECALL.
- R12: A `sw_store` pulse in idle starts a STORE whatever the dirty flag holds. A `sw_recall` pulse starts a RECALL that keeps reads closed for exactly RECALL_CYC cycles and clears the dirty flag.
- R13: Precedence, highest first: loss of the reset level, then the automatic alert, then the busy-line request, then `sw_store`, then `sw_recall`. Triggers that arrive while a cycle is active are dropped. `store_go` and `recall_go` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sup_above_sw | input | 1 | Supply comparator: 1 when above the switch level |
| sup_above_rst | input | 1 | Supply comparator: 1 when above the reset level |
| busy_in | input | 1 | Sampled level of the shared busy/request line (0 = low) |
| busy_drv | output | 1 | 1 = pull the busy line low |
| sw_store | input | 1 | Software STORE trigger pulse |
| sw_recall | input | 1 | Software RECALL trigger pulse |
| sram_rd | input | 1 | Host read strobe |
| sram_wr | input | 1 | Host write strobe |
| rd_pass | output | 1 | Read strobe after gating |
| wr_pass | output | 1 | Write strobe after gating |
| store_go | output | 1 | One-cycle STORE start to the copy engine |
| recall_go | output | 1 | One-cycle RECALL start to the copy engine |

## Verification
The bench builds the block with STORE_CYC=20, RECALL_CYC=8, RESTORE_CYC=12, DELAY_CYC=4, RECOVER_CYC=3 and ALERT_CYC=5. These are small and all different from each other. Because of that, every measured window length identifies the interval that produced it. A STORE, a RECALL and a full hold-recover sequence each fit in a few dozen cycles, so the run can combine the dirty and clean paths with supply dips, a forced-high line and concurrent triggers.

// File: rtl/nv_ctl_pkg.sv
package nv_ctl_pkg;

  typedef enum logic [3:0] {
    ST_WAKE,     // RECALL latched, waiting for supply
    ST_RESTORE,  // power-up RECALL running
    ST_IDLE,     // normal SRAM access
    ST_DELAY,    // busy line fell: window for the cycle in flight
    ST_ALERT,    // supply fell: short pull on the busy line
    ST_STORE,    // STORE running, line pulled low
    ST_HOLD,     // disabled until the line is seen high
    ST_RECOVER,  // post-hold recovery interval
    ST_RECALL    // software RECALL running
  } nv_state_e;

  function automatic int unsigned max6(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d,
                                       input int unsigned e, input int unsigned f);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    if (f > m) m = f;
    return m;
  endfunction

  // Dwell length of a timed state; untimed states report 1.
  function automatic int unsigned dwell_of(input nv_state_e s,
                                           input int unsigned t_store,
                                           input int unsigned t_recall,
                                           input int unsigned t_restore,
                                           input int unsigned t_delay,
                                           input int unsigned t_recover,
                                           input int unsigned t_alert);
    case (s)
      ST_STORE:   return t_store;
      ST_RECALL:  return t_recall;
      ST_RESTORE: return t_restore;
      ST_DELAY:   return t_delay;
      ST_RECOVER: return t_recover;
      ST_ALERT:   return t_alert;
      default:    return 1;
    endcase
  endfunction

  // Which states let reads and writes reach the array.
  function automatic logic read_window(input nv_state_e s, input logic line_hi);
    return ((s == ST_IDLE) && line_hi) || (s == ST_DELAY);
  endfunction

  function automatic logic write_window(input nv_state_e s, input logic line_hi,
                                        input logic sup_ok);
    return (s == ST_IDLE) && line_hi && sup_ok;
  endfunction

endpackage

// File: rtl/nv_dwell_timer.sv
module nv_dwell_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;

  assign expired = (cnt >= (limit - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/nv_dirty_track.sv
module nv_dirty_track (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dirty <= 1'b0;
    else if (set_i) dirty <= 1'b1;
    else if (clr_i) dirty <= 1'b0;
  end
endmodule

// File: rtl/nv_access_gate.sv
module nv_access_gate
  import nv_ctl_pkg::*;
(
  input  nv_state_e state,
  input  logic      line_hi,
  input  logic      sup_ok,
  input  logic      rd_req,
  input  logic      wr_req,
  output logic      rd_ok,
  output logic      wr_ok
);
  assign rd_ok = rd_req && read_window(state, line_hi);
  assign wr_ok = wr_req && write_window(state, line_hi, sup_ok);
endmodule

// File: rtl/nv_cycle_ctrl.sv
module nv_cycle_ctrl
  import nv_ctl_pkg::*;
#(
  parameter int unsigned STORE_CYC   = 64,
  parameter int unsigned RECALL_CYC  = 16,
  parameter int unsigned RESTORE_CYC = 32,
  parameter int unsigned DELAY_CYC   = 4,
  parameter int unsigned RECOVER_CYC = 4,
  parameter int unsigned ALERT_CYC   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_above_sw,
  input  logic sup_above_rst,
  input  logic busy_in,
  output logic busy_drv,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic sram_rd,
  input  logic sram_wr,
  output logic rd_pass,
  output logic wr_pass,
  output logic store_go,
  output logic recall_go
);
  localparam int unsigned MAX_CYC =
    max6(STORE_CYC, RECALL_CYC, RESTORE_CYC, DELAY_CYC, RECOVER_CYC, ALERT_CYC);
  localparam int CW = $clog2(MAX_CYC + 1);

  nv_state_e     state, nxt;
  logic          move;
  logic          expired;
  logic          dirty_q;
  logic          armed_q;
  logic          cycle_done;
  logic [CW-1:0] lim;

  // Named internal events
  assign move       = (nxt != state);
  assign lim        = CW'(dwell_of(state, STORE_CYC, RECALL_CYC, RESTORE_CYC,
                                   DELAY_CYC, RECOVER_CYC, ALERT_CYC));
  assign cycle_done = expired && (state inside {ST_STORE, ST_RECALL, ST_RESTORE});
  assign busy_drv   = (state == ST_ALERT) || (state == ST_STORE);

  nv_dwell_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (move),
    .limit   (lim),
    .expired (expired)
  );

  nv_dirty_track u_dirty (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wr_pass),
    .clr_i (cycle_done),
    .dirty (dirty_q)
  );

  nv_access_gate u_gate (
    .state   (state),
    .line_hi (busy_in),
    .sup_ok  (sup_above_sw),
    .rd_req  (sram_rd),
    .wr_req  (sram_wr),
    .rd_ok   (rd_pass),
    .wr_ok   (wr_pass)
  );

  always_comb begin
    nxt = state;
    case (state)
      ST_WAKE:
        if (sup_above_sw && sup_above_rst) nxt = ST_RESTORE;
      ST_RESTORE, ST_RECALL, ST_RECOVER:
        if (expired) nxt = ST_IDLE;
      ST_IDLE:
        if (!sup_above_sw && armed_q)     nxt = ST_ALERT;
        else if (!sup_above_sw)           nxt = ST_IDLE;
        else if (!busy_in)                nxt = ST_DELAY;
        else if (sw_store)                nxt = ST_STORE;
        else if (sw_recall)               nxt = ST_RECALL;
      ST_DELAY:
        if (expired) nxt = dirty_q ? ST_STORE : ST_HOLD;
      ST_ALERT:
        if (expired) begin
          if (busy_in)      nxt = ST_IDLE;
          else if (dirty_q) nxt = ST_STORE;
          else              nxt = ST_HOLD;
        end
      ST_STORE:
        if (expired) nxt = ST_HOLD;
      ST_HOLD:
        if (busy_in) nxt = ST_RECOVER;
      default: nxt = ST_WAKE;
    endcase
    if (!sup_above_rst) nxt = ST_WAKE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WAKE;
      armed_q   <= 1'b0;
      store_go  <= 1'b0;
      recall_go <= 1'b0;
    end else begin
      state     <= nxt;
      store_go  <= move && (nxt == ST_STORE);
      recall_go <= move && ((nxt == ST_RESTORE) || (nxt == ST_RECALL));
      if (sup_above_sw)                 armed_q <= 1'b1;
      else if (move && nxt == ST_ALERT) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/nv_cycle_chk.sv
module nv_cycle_chk (
  input logic clk,
  input logic rst_n,
  input logic sup_sw,
  input logic sup_rst,
  input logic busy_in,
  input logic busy_drv,
  input logic rd_pass,
  input logic wr_pass,
  input logic store_go,
  input logic recall_go,
  input logic dirty
);
  // R3
  store_go_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |-> busy_drv);
  // R10
  low_sup_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_sw |-> !wr_pass);
  // R5
  wr_line_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pass |-> busy_in);
  // R2
  wr_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pass |=> dirty);
  // R13
  one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_go, recall_go}));
  // R6
  access_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pass || wr_pass) |-> !busy_drv);
  // R11
  rst_level_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_rst |=> (!rd_pass && !wr_pass));
endmodule

bind nv_cycle_ctrl nv_cycle_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sup_sw    (sup_above_sw),
  .sup_rst   (sup_above_rst),
  .busy_in   (busy_in),
  .busy_drv  (busy_drv),
  .rd_pass   (rd_pass),
  .wr_pass   (wr_pass),
  .store_go  (store_go),
  .recall_go (recall_go),
  .dirty     (dirty_q)
);

// File: tb/sim_nv_cycle_ctrl.sv
module sim_nv_cycle_ctrl;
  localparam int CLK_P   = 10;
  localparam int T_STORE = 20;
  localparam int T_RCL   = 8;
  localparam int T_RST   = 12;
  localparam int T_DLY   = 4;
  localparam int T_REC   = 3;
  localparam int T_ALR   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_sw = 1'b1, sup_rst = 1'b1;
  logic ext_low = 1'b0, force_hi = 1'b0;
  logic sw_st = 1'b0, sw_rc = 1'b0, rd = 1'b1, wr = 1'b0;
  logic busy_drv, rd_pass, wr_pass, store_go, recall_go;
  logic busy_in;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  byte exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  // Line model: open drain with optional external pull-down or strong pull-up
  assign busy_in = force_hi ? 1'b1 : ~(busy_drv | ext_low);

  nv_cycle_ctrl #(
    .STORE_CYC(T_STORE), .RECALL_CYC(T_RCL), .RESTORE_CYC(T_RST),
    .DELAY_CYC(T_DLY), .RECOVER_CYC(T_REC), .ALERT_CYC(T_ALR)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sup_above_sw(sup_sw), .sup_above_rst(sup_rst),
    .busy_in(busy_in), .busy_drv(busy_drv), .sw_store(sw_st), .sw_recall(sw_rc),
    .sram_rd(rd), .sram_wr(wr), .rd_pass(rd_pass), .wr_pass(wr_pass),
    .store_go(store_go), .recall_go(recall_go)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: start pulses must match the expected queue
  always @(negedge clk) begin
    if (rst_n && (store_go || recall_go)) begin
      byte got;
      got = store_go ? "S" : "R";
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R13 unexpected start: actual %c expected none", got);
      end else begin
        byte want;
        want = exp_q.pop_front();
        if (want != got) begin
          n_fail++;
          $display("FAIL R2 start kind: actual %c expected %c", got, want);
        end
      end
    end
  end

  task automatic expect_evt(input byte k);
    exp_q.push_back(k);
  endtask

  task automatic measure_busy(output int n);
    int t = 0;
    while (!busy_drv && t < 200) begin @(negedge clk); t++; end
    n = 0;
    while (busy_drv && n < 500) begin n++; @(negedge clk); end
  endtask

  task automatic count_blocked(output int n);
    n = 0;
    while (!rd_pass && n < 500) begin n++; @(negedge clk); end
  endtask

  task automatic settle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic do_write(input string req);
    @(negedge clk); wr = 1'b1; #1;
    chk(req, wr_pass, 1);
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_sw(input bit st, input bit rc);
    sw_st = st; sw_rc = rc;
    @(negedge clk);
    sw_st = 1'b0; sw_rc = 1'b0;
  endtask

  // Busy-line request with a clean flag: no store, hold, then recover
  task automatic hw_clean(input string req);
    bit saw = 0;
    int n;
    @(negedge clk); ext_low = 1'b1;
    repeat (T_DLY + 4) begin @(negedge clk); if (busy_drv) saw = 1; end
    chk(req, saw, 0);
    chk("R5 closed while line low", rd_pass, 0);
    ext_low = 1'b0;
    @(negedge clk);
    count_blocked(n);
    chk("R5 recover length", n, T_REC);
  endtask

  initial begin
    int n;
    bit saw;
    // R1 reset state
    settle(2);
    chk("R1 busy_drv in reset", busy_drv, 0);
    chk("R1 rd_pass in reset", rd_pass, 0);
    chk("R1 store_go in reset", store_go, 0);
    chk("R1 recall_go in reset", recall_go, 0);
    expect_evt("R");
    rst_n = 1'b1;
    @(negedge clk);
    count_blocked(n);
    chk("R1 restore length", n, T_RST);

    // R4 clean busy-line request
    hw_clean("R4 no busy drive when clean");

    // R3 / R6 dirty busy-line request
    do_write("R2 write accepted");
    @(negedge clk); ext_low = 1'b1;
    @(negedge clk); wr = 1'b1; #1;
    chk("R6 read in delay window", rd_pass, 1);
    chk("R6 write blocked in delay window", wr_pass, 0);
    @(negedge clk); wr = 1'b0;
    expect_evt("S");
    measure_busy(n);
    chk("R3 store length", n, T_STORE);
    chk("R5 closed after store", rd_pass, 0);
    settle(2);
    chk("R5 still closed while line low", rd_pass, 0);
    ext_low = 1'b0;
    @(negedge clk);
    count_blocked(n);
    chk("R5 recover after store", n, T_REC);
    hw_clean("R2 flag cleared by store");

    // R7 automatic alert with clean flag
    @(negedge clk); sup_sw = 1'b0;
    measure_busy(n);
    chk("R7 alert length clean", n, T_ALR);
    settle(T_REC + 3);
    @(negedge clk); wr = 1'b1; #1;
    chk("R10 write blocked below switch", wr_pass, 0);
    @(negedge clk); wr = 1'b0; sup_sw = 1'b1;
    settle(3);

    // R9 abandon when line held high, R10 no busy-line store below switch
    do_write("R2 write before abandon");
    @(negedge clk); force_hi = 1'b1; sup_sw = 1'b0;
    measure_busy(n);
    chk("R9 alert length abandoned", n, T_ALR);
    chk("R9 access reopens", rd_pass, 1);
    force_hi = 1'b0; ext_low = 1'b1;
    saw = 0;
    repeat (10) begin @(negedge clk); if (busy_drv) saw = 1; end
    chk("R10 no store below switch", saw, 0);
    ext_low = 1'b0; sup_sw = 1'b1;
    settle(3);
    @(negedge clk); ext_low = 1'b1;
    expect_evt("S");
    measure_busy(n);
    chk("R9 flag kept after abandon", n, T_STORE);
    ext_low = 1'b0;
    @(negedge clk);
    count_blocked(n);
    chk("R5 recover length again", n, T_REC);

    // R8 automatic store with dirty flag; R11 dip above reset level
    do_write("R2 write before auto store");
    @(negedge clk); sup_sw = 1'b0;
    expect_evt("S");
    measure_busy(n);
    chk("R8 alert plus store length", n, T_ALR + T_STORE);
    settle(T_REC + 3);
    sup_sw = 1'b1;
    settle(5);
    chk("R11 no recall after shallow dip", rd_pass, 1);

    // R11 drop below reset level
    do_write("R2 write before brown-out");
    @(negedge clk); sup_rst = 1'b0; sup_sw = 1'b0;
    @(negedge clk); wr = 1'b1; #1;
    chk("R11 read closed below reset", rd_pass, 0);
    chk("R11 write closed below reset", wr_pass, 0);
    wr = 1'b0;
    settle(3);
    expect_evt("R");
    sup_rst = 1'b1; sup_sw = 1'b1;
    @(negedge clk);
    count_blocked(n);
    chk("R11 recall length after brown-out", n, T_RST);
    hw_clean("R2 flag cleared by recall");

    // R12 software store on clean flag; R13 recall in same cycle dropped
    @(negedge clk);
    expect_evt("S");
    pulse_sw(1'b1, 1'b1);
    measure_busy(n);
    chk("R12 software store length", n, T_STORE);
    pulse_sw(1'b0, 1'b1);
    settle(T_REC + 3);
    chk("R13 recall during active cycle dropped", rd_pass, 1);

    // R12 software recall clears flag
    do_write("R2 write before software recall");
    @(negedge clk);
    expect_evt("R");
    pulse_sw(1'b0, 1'b1);
    count_blocked(n);
    chk("R12 software recall length", n, T_RCL);
    hw_clean("R12 flag cleared by software recall");

    // R13 alert takes precedence over a software store
    @(negedge clk); sup_sw = 1'b0;
    pulse_sw(1'b1, 1'b0);
    measure_busy(n);
    chk("R13 alert wins over software store", n, T_ALR);
    settle(T_REC + 3);
    sup_sw = 1'b1;
    settle(4);

    chk("R13 all expected starts seen", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule